// File: doc/BRIEF.md
# Per-pin configurable GPIO port with combined interrupt

This block is one general-purpose I/O port of up to 32 pins. Software reaches it through a plain synchronous register port with one-cycle read latency. For each pin it can:

- pick the direction;
- drive all outputs with one word, or set and clear chosen bits through dedicated mask registers;
- read back the level of every pin as one word.

External inputs pass through a two-flop synchronizer. Each pin can then take an optional debounce filter that accepts a new level only after it has held for `DEB_CYC` cycles.

Every pin has its own interrupt setup: an enable bit, a level or edge mode, a polarity and a both-edges override. Pins that trigger are recorded in a status word. A status bit set by an edge holds until software writes 1 to that bit of the acknowledge register. A status bit set by a level follows the qualified input. A mask register selects which status bits may raise the single registered interrupt line.

Top module: `pinbank_ctrl`

## Requirements
- R1: After reset, `pin_out`, `pin_oe`, `irq` and the status word (address 11) are all zero, and every configuration register reads zero.
- R2: Bit i of the direction register (address 1) drives `pin_oe[i]`: 1 makes the pin an output, 0 an input. The register reads back its written value.
- R3: A write to address 0 loads every output bit. A write to address 3 sets only the bits given as 1, and a write to address 4 clears only the bits given as 1. `pin_out` changes only in response to a write.
- R4: Reading address 2 returns, per pin, the driven output value for output pins and the synchronized (and optionally filtered) input level for input pins.
- R5: With debounce bit i set (address 9), a change of `pin_in[i]` that lasts fewer than `DEB_CYC` cycles leaves the level seen at address 2 unchanged. A change that holds is accepted after `DEB_CYC` cycles.
- R6: With mode bit 0 (level mode, address 6), status bit i is 1 exactly while the input matches its polarity bit (address 7: 1 = active high, 0 = active low). Writing 1 to the acknowledge register (address 12) does not clear it while the level is active.
- R7: With mode bit 1 (edge mode), polarity 1 triggers on a rising edge and 0 on a falling edge. The status bit stays set until 1 is written to that bit of address 12.
- R8: With both-edges bit i set (address 8) in edge mode, both rising and falling edges trigger, whatever the polarity bit holds.
- R9: A pin can set its status bit only when its enable bit (address 5) is 1 and the pin is an input.
- R10: `irq` is the OR of status AND mask (address 10, 1 = unmasked), registered. It changes in the cycle after the status or the mask changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read strobe |
| pin_in | input | N_PINS | External pin levels (asynchronous) |
| pin_out | output | N_PINS | Output data |
| pin_oe | output | N_PINS | Output enable per pin |
| irq | output | 1 | Combined registered interrupt |

## Verification
The bench builds the port with `N_PINS` = 8 and `DEB_CYC` = 4. With only 8 pins, input pins and output pins sit side by side in one small word, so readback mixing, set and clear masking, and the enable and direction gating can each be checked on neighbouring bits. The short debounce window lets a 2-cycle glitch be rejected and a held level be accepted within a few cycles. Cycle-exact checks of the mask and acknowledge paths confirm that `irq` lags its cause by exactly one register stage.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;

  localparam int unsigned BUS_W  = 32;
  localparam int unsigned ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    RG_OUT   = 4'd0,
    RG_DIR   = 4'd1,
    RG_LEVEL = 4'd2,
    RG_SET   = 4'd3,
    RG_CLR   = 4'd4,
    RG_IEN   = 4'd5,
    RG_MODE  = 4'd6,
    RG_POL   = 4'd7,
    RG_BOTH  = 4'd8,
    RG_DEB   = 4'd9,
    RG_MASK  = 4'd10,
    RG_STAT  = 4'd11,
    RG_ACK   = 4'd12
  } reg_sel_e;

  // level mode: is the pin at its active level
  function automatic logic lvl_active(logic f, logic pol);
    return pol ? f : ~f;
  endfunction

  // edge mode: did the selected transition occur
  function automatic logic edge_seen(logic f, logic fp, logic pol, logic both);
    logic rise;
    logic fall;
    rise = f & ~fp;
    fall = ~f & fp;
    return both ? (rise | fall) : (pol ? rise : fall);
  endfunction

endpackage

// File: rtl/pinbank_filter.sv
module pinbank_filter #(
  parameter int unsigned DEB_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  input  logic deb_en,
  output logic level
);
  localparam int unsigned CNT_W = $clog2(DEB_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DEB_CYC - 1);

  logic s1, s2, filt;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1   <= 1'b0;
      s2   <= 1'b0;
      filt <= 1'b0;
      cnt  <= '0;
    end else begin
      s1 <= raw;
      s2 <= s1;
      if (!deb_en) begin
        filt <= s2;
        cnt  <= '0;
      end else if (s2 == filt) begin
        cnt <= '0;
      end else if (cnt == CNT_LAST) begin
        filt <= s2;
        cnt  <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign level = filt;

  a_r5_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CNT_W'(DEB_CYC));

  // R5: under debounce the filtered value only moves to a level held at least two samples
  a_r5_settled: assert property (@(posedge clk) disable iff (!rst_n)
    (deb_en && $past(deb_en) && (filt != $past(filt)))
      |-> (($past(s2) == filt) && ($past(s2, 2) == filt)));

endmodule

// File: rtl/pinbank_detect.sv
module pinbank_detect
  import pinbank_pkg::*;
#(
  parameter int unsigned N_PINS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PINS-1:0] level,
  input  logic [N_PINS-1:0] en,
  input  logic [N_PINS-1:0] mode,
  input  logic [N_PINS-1:0] pol,
  input  logic [N_PINS-1:0] both,
  input  logic [N_PINS-1:0] is_out,
  input  logic [N_PINS-1:0] ack,
  output logic [N_PINS-1:0] stat
);
  logic [N_PINS-1:0] prev_q;
  logic [N_PINS-1:0] stat_q;
  logic [N_PINS-1:0] hit;
  logic [N_PINS-1:0] stat_nxt;

  for (genvar i = 0; i < N_PINS; i++) begin : g_pin
    logic trig;
    assign trig = mode[i] ? edge_seen(level[i], prev_q[i], pol[i], both[i])
                          : lvl_active(level[i], pol[i]);
    assign hit[i]      = trig & en[i] & ~is_out[i];
    assign stat_nxt[i] = mode[i] ? (hit[i] | (stat_q[i] & ~ack[i])) : hit[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      stat_q <= '0;
    end else begin
      prev_q <= level;
      stat_q <= stat_nxt;
    end
  end

  assign stat = stat_q;

  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(stat_q & mode & ~ack) & ~stat_q) == '0);

  a_r9_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (~$past(stat_q) & stat_q & ~($past(en) & ~$past(is_out))) == '0);

endmodule

// File: rtl/pinbank_regs.sv
module pinbank_regs
  import pinbank_pkg::*;
#(
  parameter int unsigned N_PINS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic [N_PINS-1:0] level,
  input  logic [N_PINS-1:0] stat,
  output logic [N_PINS-1:0] out_q,
  output logic [N_PINS-1:0] dir_q,
  output logic [N_PINS-1:0] ien_q,
  output logic [N_PINS-1:0] mode_q,
  output logic [N_PINS-1:0] pol_q,
  output logic [N_PINS-1:0] both_q,
  output logic [N_PINS-1:0] deb_q,
  output logic [N_PINS-1:0] mask_q,
  output logic [N_PINS-1:0] ack
);
  logic              wr_en;
  logic              rd_en;
  logic [N_PINS-1:0] wd;
  logic [N_PINS-1:0] rd_level;
  logic [N_PINS-1:0] rd_mux;
  reg_sel_e          sel;

  assign sel      = reg_sel_e'(bus_addr);
  assign wr_en    = bus_en & bus_we;
  assign rd_en    = bus_en & ~bus_we;
  assign wd       = bus_wdata[N_PINS-1:0];
  assign ack      = (wr_en && sel == RG_ACK) ? wd : '0;
  assign rd_level = (out_q & dir_q) | (level & ~dir_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q  <= '0;
      dir_q  <= '0;
      ien_q  <= '0;
      mode_q <= '0;
      pol_q  <= '0;
      both_q <= '0;
      deb_q  <= '0;
      mask_q <= '0;
    end else if (wr_en) begin
      case (sel)
        RG_OUT:  out_q  <= wd;
        RG_SET:  out_q  <= out_q | wd;
        RG_CLR:  out_q  <= out_q & ~wd;
        RG_DIR:  dir_q  <= wd;
        RG_IEN:  ien_q  <= wd;
        RG_MODE: mode_q <= wd;
        RG_POL:  pol_q  <= wd;
        RG_BOTH: both_q <= wd;
        RG_DEB:  deb_q  <= wd;
        RG_MASK: mask_q <= wd;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (sel)
      RG_OUT:   rd_mux = out_q;
      RG_DIR:   rd_mux = dir_q;
      RG_LEVEL: rd_mux = rd_level;
      RG_IEN:   rd_mux = ien_q;
      RG_MODE:  rd_mux = mode_q;
      RG_POL:   rd_mux = pol_q;
      RG_BOTH:  rd_mux = both_q;
      RG_DEB:   rd_mux = deb_q;
      RG_MASK:  rd_mux = mask_q;
      RG_STAT:  rd_mux = stat;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     bus_rdata <= '0;
    else if (rd_en) bus_rdata <= BUS_W'(rd_mux);
  end

  a_r3_out_only_by_write: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en) |-> $stable(out_q));

endmodule

// File: rtl/pinbank_ctrl.sv
module pinbank_ctrl
  import pinbank_pkg::*;
#(
  parameter int unsigned N_PINS  = 32,
  parameter int unsigned DEB_CYC = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic [N_PINS-1:0] pin_in,
  output logic [N_PINS-1:0] pin_out,
  output logic [N_PINS-1:0] pin_oe,
  output logic              irq
);
  logic [N_PINS-1:0] level, stat, ack;
  logic [N_PINS-1:0] out_q, dir_q, ien_q, mode_q, pol_q, both_q, deb_q, mask_q;
  logic              irq_q;

  for (genvar i = 0; i < N_PINS; i++) begin : g_filt
    pinbank_filter #(.DEB_CYC(DEB_CYC)) filt_i (
      .clk(clk), .rst_n(rst_n), .raw(pin_in[i]),
      .deb_en(deb_q[i]), .level(level[i])
    );
  end

  pinbank_regs #(.N_PINS(N_PINS)) regs_i (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .level(level), .stat(stat), .out_q(out_q), .dir_q(dir_q),
    .ien_q(ien_q), .mode_q(mode_q), .pol_q(pol_q), .both_q(both_q),
    .deb_q(deb_q), .mask_q(mask_q), .ack(ack)
  );

  pinbank_detect #(.N_PINS(N_PINS)) det_i (
    .clk(clk), .rst_n(rst_n), .level(level), .en(ien_q), .mode(mode_q),
    .pol(pol_q), .both(both_q), .is_out(dir_q), .ack(ack), .stat(stat)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |(stat & mask_q);
  end

  assign pin_out = out_q;
  assign pin_oe  = dir_q;
  assign irq     = irq_q;

  a_r10_rise_needs_status: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> ($past(stat) != '0));

  a_r10_quiet_when_masked: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mask_q) == '0) |-> !irq_q);

endmodule

// File: tb/pinbank_ctrl_tb.sv
module pinbank_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NP  = 8;
  localparam int DEB = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_en = 1'b0, bus_we = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NP-1:0] pin_in = '0;
  logic [NP-1:0] pin_out, pin_oe;
  logic irq;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_seen = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pinbank_ctrl #(.N_PINS(NP), .DEB_CYC(DEB)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_en = 0; bus_we = 0;
  endtask

  // driver: issue a read and push what the requirement predicts
  task automatic rd(logic [3:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    bus_en = 1; bus_we = 0; bus_addr = a;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(posedge clk);
    @(negedge clk);
    bus_en = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: read data is valid after the edge that accepted the read
  always @(posedge clk) rd_seen <= bus_en & ~bus_we;
  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) begin
        checks++; failures++;
        $display("FAIL monitor actual=%h expected=none", bus_rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, bus_rdata, e);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    // R1 reset state
    check("R1 pin_out", 32'(pin_out), 0);
    check("R1 pin_oe", 32'(pin_oe), 0);
    check("R1 irq", 32'(irq), 0);
    rd(4'd11, 0, "R1 status");
    rd(4'd6, 0, "R1 mode cfg");
    rd(4'd2, 0, "R1 level");

    // R2 direction
    wr(4'd1, 32'h0F);
    check("R2 pin_oe", 32'(pin_oe), 32'h0F);
    rd(4'd1, 32'h0F, "R2 dir readback");

    // R3 whole-word write, set, clear
    wr(4'd0, 32'hA5);
    check("R3 write word", 32'(pin_out), 32'hA5);
    wr(4'd3, 32'h02);
    check("R3 set", 32'(pin_out), 32'hA7);
    wr(4'd4, 32'h81);
    check("R3 clear", 32'(pin_out), 32'h26);
    idle(3);
    check("R3 hold", 32'(pin_out), 32'h26);
    rd(4'd0, 32'h26, "R3 out readback");

    // R4 mixed level readback
    pin_in = 8'h30;
    idle(5);
    rd(4'd2, 32'h36, "R4 level mix");

    // R5 debounce
    wr(4'd9, 32'h80);
    pin_in = 8'hB0;
    idle(2);
    pin_in = 8'h30;
    idle(10);
    rd(4'd2, 32'h36, "R5 glitch rejected");
    pin_in = 8'hB0;
    idle(10);
    rd(4'd2, 32'hB6, "R5 held level accepted");
    pin_in = 8'h30;
    idle(10);
    wr(4'd9, 32'h00);

    // R6 level mode, active high on pin4 (already high)
    wr(4'd10, 32'hFF);
    wr(4'd7, 32'h10);
    wr(4'd6, 32'h00);
    wr(4'd5, 32'h10);
    idle(4);
    rd(4'd11, 32'h10, "R6 level status");
    check("R6 irq", 32'(irq), 1);
    wr(4'd12, 32'h10);
    idle(2);
    rd(4'd11, 32'h10, "R6 ack ignored while active");
    pin_in = 8'h20;
    idle(6);
    rd(4'd11, 32'h00, "R6 level released");
    check("R6 irq low", 32'(irq), 0);

    // R7 edge mode on pin6
    wr(4'd5, 32'h40);
    wr(4'd6, 32'h40);
    wr(4'd7, 32'h40);
    pin_in = 8'h60;
    idle(6);
    rd(4'd11, 32'h40, "R7 rising");
    pin_in = 8'h20;
    idle(6);
    rd(4'd11, 32'h40, "R7 sticky");
    wr(4'd12, 32'h40);
    rd(4'd11, 32'h00, "R7 ack clears");
    wr(4'd7, 32'h00);
    pin_in = 8'h60;
    idle(6);
    rd(4'd11, 32'h00, "R7 falling ignores rise");
    pin_in = 8'h20;
    idle(6);
    rd(4'd11, 32'h40, "R7 falling");
    wr(4'd12, 32'h40);

    // R8 both edges
    wr(4'd8, 32'h40);
    pin_in = 8'h60;
    idle(6);
    rd(4'd11, 32'h40, "R8 rise with both");
    wr(4'd12, 32'h40);
    rd(4'd11, 32'h00, "R8 ack");
    pin_in = 8'h20;
    idle(6);
    rd(4'd11, 32'h40, "R8 fall with both");
    wr(4'd12, 32'h40);

    // R10 mask and registered line, cycle exact
    pin_in = 8'h60;
    idle(6);
    wr(4'd10, 32'h00);
    idle(3);
    check("R10 masked", 32'(irq), 0);
    wr(4'd10, 32'h40);
    check("R10 one cycle lag", 32'(irq), 0);
    @(negedge clk);
    check("R10 raised", 32'(irq), 1);
    wr(4'd12, 32'h40);
    check("R10 lag on clear", 32'(irq), 1);
    @(negedge clk);
    check("R10 dropped", 32'(irq), 0);

    // R9 enable and direction gating
    wr(4'd8, 32'h00);
    wr(4'd6, 32'hFF);
    wr(4'd7, 32'hFF);
    wr(4'd5, 32'h41);
    pin_in = 8'h00;
    idle(6);
    pin_in = 8'h21;
    idle(6);
    rd(4'd11, 32'h00, "R9 disabled and output pins");
    check("R9 irq", 32'(irq), 0);
    wr(4'd5, 32'h21);
    pin_in = 8'h00;
    idle(6);
    pin_in = 8'h20;
    idle(6);
    rd(4'd11, 32'h20, "R9 enabled input triggers");

    idle(4);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule